// File: doc/BRIEF.md
# Bus-Mapped Four-Channel Stepper Control Register

This block places one byte of control storage at a single location in a 16-bit processor address space. The full address is compared against a 16-bit strap word, and the result is qualified by a bus select line. A match raises a memory-disable flag, so that any memory overlapping that location stays silent. The match is also combined with the processor's read and write controls to form separate read and write strobes.

The write strobe is further gated by a bus timing signal. A mode input picks that signal: either an E-clock style phase clock, or an 8051-style write strobe. A qualified write loads the data bus into the register on the next rising clock edge. Each bit of the held byte then drives a direction or step line for one of four stepper channels.

A read puts the held byte back on the data bus with an output-enable flag. Software can therefore read, change one bit and write the byte back, for example to toggle a single step line.

Top module: `stp_bus_reg`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising clock edge, the held byte becomes 0x00. After that edge every direction and step line is low, and `data_oe` is low while no read is addressed.
- R2: `mem_disable` is high in the same cycle, with no clock delay, exactly when `bus_sel` is high and `addr` equals `strap_addr` in all 16 bits.
- R3: When `mem_disable`, `wr_en` and the selected timing qualifier are all high, the rising clock edge loads `data_in` into the held byte. The qualifier is `e_clk` when `timing_sel` is 0 and `wr_strobe` when `timing_sel` is 1.
- R4: In any cycle without a qualified write, the held byte keeps its value. This covers a wrong address, `bus_sel` low, `wr_en` low, or the selected qualifier low, even when the other qualifier is high.
- R5: `data_oe` is high exactly when `mem_disable` and `rd_en` are high and `wr_en` is low. While it is high, `data_out` equals the held byte. While it is low, `data_out` is 0x00.
- R6: Held-byte bit 2k drives `motor_dir[k]` and bit 2k+1 drives `motor_step[k]`, for k = 0..3.
- R7: When a read and a write address the block in the same cycle, the write is carried out and `data_oe` stays low.
- R8: A change of `strap_addr` moves the block to the new address at once. The held byte is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Processor address |
| strap_addr | input | 16 | Strapped address the block answers at |
| bus_sel | input | 1 | Address strobe / external select qualifier, active high |
| rd_en | input | 1 | Processor output-enable (read), active high |
| wr_en | input | 1 | Processor write, active high |
| timing_sel | input | 1 | Write qualifier select: 0 = E clock, 1 = 8051 strobe |
| e_clk | input | 1 | E-clock style timing signal |
| wr_strobe | input | 1 | 8051-style write strobe, active high |
| data_in | input | 8 | Write data from the processor |
| data_out | output | 8 | Read-back data |
| data_oe | output | 1 | Data bus drive enable |
| mem_disable | output | 1 | High while the block's address is selected |
| motor_dir | output | 4 | Direction line per channel |
| motor_step | output | 4 | Step line per channel |

## Verification
A corrupted held byte shows up on the motor lines in the cycle after the faulty edge. It also shows on `data_out` at the next addressed read, so every cycle of the random run compares all eight motor lines against the model. A wrong decode or a wrong strobe gate does not wait for a clock edge. It appears as a wrong `mem_disable` or `data_oe` in the same cycle. It can also appear as a missed or spurious load one cycle later. Bursts of writes with the unselected qualifier toggling, reads that overlap writes, and a strap relocation are placed so that each of these faults reaches the ports within one cycle.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int ADDR_W   = 16;
    localparam int CHANNELS = 4;
    localparam int DATA_W   = 2 * CHANNELS;

    typedef enum logic {
        QUAL_ECLK   = 1'b0,
        QUAL_STROBE = 1'b1
    } qual_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] held;
    } reg_state_t;

endpackage

// File: rtl/stp_addr_match.sv
module stp_addr_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] strap,
    input  logic          bus_sel,
    output logic          match
);
    logic [AW-1:0] bit_eq;

    for (genvar i = 0; i < AW; i++) begin : g_cmp
        assign bit_eq[i] = ~(addr[i] ^ strap[i]);
    end

    assign match = bus_sel & (&bit_eq);
endmodule

// File: rtl/stp_strobe_gen.sv
module stp_strobe_gen
    import stp_pkg::*;
(
    input  logic match,
    input  logic rd_en,
    input  logic wr_en,
    input  logic timing_sel,
    input  logic e_clk,
    input  logic wr_strobe,
    output logic rd_stb,
    output logic wr_stb
);
    qual_mode_e mode;
    logic       qual;

    always_comb begin
        mode = qual_mode_e'(timing_sel);
        case (mode)
            QUAL_ECLK:   qual = e_clk;
            QUAL_STROBE: qual = wr_strobe;
            default:     qual = 1'b0;
        endcase
        wr_stb = match & wr_en & qual;
        rd_stb = match & rd_en & ~wr_en;
    end
endmodule

// File: rtl/stp_ctrl_reg.sv
module stp_ctrl_reg
    import stp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_stb,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] held
);
    typedef struct packed {
        logic [DW-1:0] value;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.value = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held = st_q.value;

    a_r4_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |=> $stable(held));
    a_r3_capture_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> held == $past(wdata));
endmodule

// File: rtl/stp_bus_reg.sv
module stp_bus_reg
    import stp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] strap_addr,
    input  logic              bus_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              timing_sel,
    input  logic              e_clk,
    input  logic              wr_strobe,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              mem_disable,
    output logic [CHANNELS-1:0] motor_dir,
    output logic [CHANNELS-1:0] motor_step
);
    logic              match;
    logic              rd_stb;
    logic              wr_stb;
    logic [DATA_W-1:0] held;

    stp_addr_match #(.AW(ADDR_W)) u_match (
        .addr    (addr),
        .strap   (strap_addr),
        .bus_sel (bus_sel),
        .match   (match)
    );

    stp_strobe_gen u_strobe (
        .match      (match),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .timing_sel (timing_sel),
        .e_clk      (e_clk),
        .wr_strobe  (wr_strobe),
        .rd_stb     (rd_stb),
        .wr_stb     (wr_stb)
    );

    stp_ctrl_reg #(.DW(DATA_W)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .wr_stb (wr_stb),
        .wdata  (data_in),
        .held   (held)
    );

    assign mem_disable = match;
    assign data_oe     = rd_stb;
    assign data_out    = rd_stb ? held : '0;

    for (genvar k = 0; k < CHANNELS; k++) begin : g_chan
        assign motor_dir[k]  = held[2*k];
        assign motor_step[k] = held[2*k+1];
    end

    a_r2_strobe_needs_match: assert property (@(posedge clk) disable iff (rst)
        (rd_stb || wr_stb) |-> mem_disable);
    a_r7_no_drive_during_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !data_oe);
    a_r5_readback_value: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (data_out == held));
    a_r2_no_select_no_flag: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |-> !mem_disable);
endmodule

// File: tb/tb_stp_bus_reg.sv
`timescale 1ns/1ps
module tb_stp_bus_reg;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] strap_addr = 16'h8000;
    logic        bus_sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        timing_sel = 1'b0;
    logic        e_clk = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        mem_disable;
    logic [3:0]  motor_dir;
    logic [3:0]  motor_step;

    int total = 0;
    int bad = 0;
    logic [7:0] model = '0;
    int unsigned seed_v;

    always #2.5 clk = ~clk;

    stp_bus_reg dut (
        .clk(clk), .rst(rst), .addr(addr), .strap_addr(strap_addr),
        .bus_sel(bus_sel), .rd_en(rd_en), .wr_en(wr_en),
        .timing_sel(timing_sel), .e_clk(e_clk), .wr_strobe(wr_strobe),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .mem_disable(mem_disable), .motor_dir(motor_dir), .motor_step(motor_step)
    );

    function automatic logic f_match();
        return bus_sel && (addr == strap_addr);
    endfunction

    function automatic logic f_write();
        return f_match() && wr_en && (timing_sel ? wr_strobe : e_clk);
    endfunction

    function automatic logic f_oe();
        return f_match() && rd_en && !wr_en;
    endfunction

    function automatic logic [3:0] f_dir(input logic [7:0] b);
        return {b[6], b[4], b[2], b[0]};
    endfunction

    function automatic logic [3:0] f_step(input logic [7:0] b);
        return {b[7], b[5], b[3], b[1]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // check combinational outputs and motor lines in the current cycle
    task automatic check_now(input string tag);
        chk({tag, " R2 mem_disable"}, 32'(mem_disable), 32'(f_match()));
        chk({tag, " R5 R7 data_oe"}, 32'(data_oe), 32'(f_oe()));
        chk({tag, " R5 data_out"}, 32'(data_out), f_oe() ? 32'(model) : 32'h0);
        chk({tag, " R6 motor_dir"}, 32'(motor_dir), 32'(f_dir(model)));
        chk({tag, " R6 motor_step"}, 32'(motor_step), 32'(f_step(model)));
    endtask

    // inputs settle after negedge; check; then the posedge commits
    task automatic cycle(input string tag);
        #1;
        check_now(tag);
        @(posedge clk);
        if (f_write()) model = data_in;
        @(negedge clk);
    endtask

    task automatic drive(input logic [15:0] a, input logic bs, input logic rd,
                         input logic wr, input logic ts, input logic ec,
                         input logic ws, input logic [7:0] d);
        addr = a; bus_sel = bs; rd_en = rd; wr_en = wr;
        timing_sel = ts; e_clk = ec; wr_strobe = ws; data_in = d;
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        seed_v = 32'd20240611;
        void'($urandom(seed_v));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        // R1: reset state
        #1;
        chk("R1 dir after reset", 32'(motor_dir), 32'h0);
        chk("R1 step after reset", 32'(motor_step), 32'h0);
        chk("R1 oe after reset", 32'(data_oe), 32'h0);

        // R3: E-clock qualified write, then read back
        drive(16'h8000, 1, 0, 1, 0, 1, 0, 8'hA5); cycle("R3 eclk write");
        drive(16'h8000, 1, 1, 0, 0, 0, 0, 8'h00); cycle("R5 read");
        // R6: single-bit patterns per channel
        drive(16'h8000, 1, 0, 1, 0, 1, 0, 8'h02); cycle("R6 ch0 step");
        drive(16'h8000, 1, 0, 1, 0, 1, 0, 8'h40); cycle("R6 ch3 dir");
        drive(16'h8000, 1, 0, 0, 0, 0, 0, 8'h00); cycle("R6 hold");
        // R4: other qualifier high but selected low
        drive(16'h8000, 1, 0, 1, 0, 0, 1, 8'hFF); cycle("R4 eclk low strobe high");
        drive(16'h8000, 1, 0, 1, 1, 1, 0, 8'hFF); cycle("R4 strobe low eclk high");
        // R3: 8051-style strobe mode
        drive(16'h8000, 1, 0, 1, 1, 0, 1, 8'h3C); cycle("R3 strobe write");
        // R4: wrong address, bus_sel low
        drive(16'h8001, 1, 0, 1, 1, 1, 1, 8'h11); cycle("R4 wrong addr");
        drive(16'h8000, 0, 0, 1, 1, 1, 1, 8'h22); cycle("R4 bus_sel low");
        // R7: read and write overlap, write wins
        drive(16'h8000, 1, 1, 1, 0, 1, 0, 8'hC3); cycle("R7 overlap");
        drive(16'h8000, 1, 1, 0, 0, 0, 0, 8'h00); cycle("R7 readback");
        // R8: relocate
        strap_addr = 16'hBC00;
        drive(16'h8000, 1, 1, 0, 0, 0, 0, 8'h00); cycle("R8 old addr");
        drive(16'hBC00, 1, 1, 0, 0, 0, 0, 8'h00); cycle("R8 new addr read");
        drive(16'hBC00, 1, 0, 1, 1, 0, 1, 8'h5A); cycle("R8 new addr write");
        strap_addr = 16'h8000;

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            a = ($urandom % 2) ? strap_addr : 16'($urandom);
            if (($urandom % 16) == 0) strap_addr = 16'($urandom);
            drive(a, 1'($urandom % 4 != 0), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom));
            cycle("R3 R4 R5 random");
        end

        // R1: reset mid-run clears the byte
        drive(strap_addr, 0, 0, 0, 0, 0, 0, 8'h00);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0; model = '0;
        #1;
        chk("R1 dir after mid reset", 32'(motor_dir), 32'h0);
        chk("R1 step after mid reset", 32'(motor_step), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule